// File: doc/BRIEF.md
# Prescaled Watchdog and Interval Timer

The block watches for a stalled processor. A 12-bit prescaler counts ticks from one of two sources: every cycle of the peripheral clock, or pulses on a slow watchdog-oscillator tick input. One prescaler bit, picked by a 3-bit tap select, sets the rate at which an 8-bit down counter decrements. If software does not feed the counter in time, the counter underflows and the block raises a one-cycle system reset request.

When the watchdog function is switched off, the same datapath works as a periodic interval timer. An underflow then sets an interrupt flag, and the counter reloads itself so that the next period starts at once.

Software drives the block through a small byte-wide register port. A feed takes two consecutive writes to the feed address: 0xA5, then 0x5A. A feed loads the counter from the reload register and clears the prescaler. The block's own reset request never clears its state; only the power-on reset does. A power-down input freezes counting while the peripheral clock is the selected source.

Top module: `guard_timer`

## Requirements
- R1: After power-on reset, the control register reads 0x02, the reload register reads 0xFF, the counter reads 0xFF, and `reset_req` and `irq` are low.
- R2: Register map (`addr`):
  - 0 is the control register, which reads back as written with the flag in bit 6.
    - bit 0: run.
    - bit 1: watchdog mode (1 = reset, 0 = interval).
    - bit 2: source (1 = oscillator tick, 0 = peripheral clock).
    - bits 5:3: tap select.
    - bit 6: interrupt flag.
  - 1 is the reload register.
  - 2 is the feed register for writes; a read of address 2 returns the live counter.
- R3: A write of 0x5A to address 2 feeds the counter only if the last write before it was 0xA5 to address 2. Idle cycles in between are allowed; any other write in between cancels the sequence. A feed loads the counter from the reload register and clears the prescaler, even while run is 0.
- R4: With reload value R and tap select T, the first underflow occurs (R+1)·2^(T+5) source ticks after the feed edge, because tap select T uses prescaler bit T+4.
- R5: In watchdog mode, an underflow makes `reset_req` high for exactly one cycle, leaves `irq` unchanged, and reloads the counter.
- R6: In interval mode, an underflow sets the interrupt flag and never asserts `reset_req`. The counter reloads itself, so underflows repeat every (R+1)·2^(T+5) ticks without a feed.
- R7: Writing 0 to bit 6 of the control register clears the flag. Writing 1 there does not set it.
- R8: With the source set to the oscillator, the prescaler advances only on cycles where `osc_tick` is high. With the source set to the peripheral clock, it advances every cycle.
- R9: With the peripheral clock selected and `pwr_down` high, the counter and the prescaler hold. `pwr_down` has no effect when the oscillator source is selected.
- R10: The control and reload registers keep their values across an asserted `reset_req`; only `por_n` clears them.
- R11: With run at 0, the counter and the prescaler hold, except when a feed loads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, also the register port clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| osc_tick | input | 1 | Watchdog oscillator tick, synchronous to clk |
| pwr_down | input | 1 | Power-down indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| reset_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interval timer interrupt flag |

## Verification
- **Reads and writes.** Register reads are combinational, so a value written at a rising edge can be read in the low half of that same cycle.
- **Feeds.** A feed takes effect at the edge that captures 0x5A.
- **Timeouts.** The underflow lands exactly (R+1)·2^(T+5) edges after the feed edge. `reset_req` or `irq` is high in the cycle after that edge, and `reset_req` drops again one edge later.
- **Sampling.** The bench counts rising edges from the feed and samples every output at the following falling edge. Each timeout is therefore compared as an exact edge count, not as a window.

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int PRE_W = 12,
  parameter int CNT_W = 8,
  parameter int TSEL_W = 3,
  parameter logic [CNT_W-1:0] FEED_A = 8'hA5,
  parameter logic [CNT_W-1:0] FEED_B = 8'h5A
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             osc_tick,
  input  logic             pwr_down,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             reset_req,
  output logic             irq
);
  localparam logic [TSEL_W-1:0] TMAX = '1;
  localparam int FLAG_B = TSEL_W + 3;

  logic              run, wd_mode, src_osc, irq_q, armed, rst_q;
  logic [TSEL_W-1:0] tap;
  logic [CNT_W-1:0]  reload, cnt;
  logic [PRE_W-1:0]  pre, tap_mask;
  logic              wr_ctrl, wr_rel, wr_feed, feed_ok, tick, dec, uflow;

  assign wr_ctrl  = wr_en && addr == 2'd0;
  assign wr_rel   = wr_en && addr == 2'd1;
  assign wr_feed  = wr_en && addr == 2'd2;
  assign feed_ok  = wr_feed && armed && wr_data == FEED_B;

  assign tick     = run && (src_osc ? osc_tick : !pwr_down);
  assign tap_mask = {PRE_W{1'b1}} >> (TMAX - tap);
  assign dec      = tick && ((pre & tap_mask) == tap_mask);
  assign uflow    = dec && cnt == '0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      run     <= 1'b0;
      wd_mode <= 1'b1;
      src_osc <= 1'b0;
      tap     <= '0;
      reload  <= '1;
    end else begin
      if (wr_ctrl) begin
        run     <= wr_data[0];
        wd_mode <= wr_data[1];
        src_osc <= wr_data[2];
        tap     <= wr_data[3 +: TSEL_W];
      end
      if (wr_rel) reload <= wr_data;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) irq_q <= 1'b0;
    else if (uflow && !wd_mode) irq_q <= 1'b1;
    else if (wr_ctrl && !wr_data[FLAG_B]) irq_q <= 1'b0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) armed <= 1'b0;
    else if (wr_en) armed <= wr_feed && wr_data == FEED_A;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pre <= '0;
    else if (feed_ok) pre <= '0;
    else if (tick) pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) cnt <= '1;
    else if (feed_ok || uflow) cnt <= reload;
    else if (dec) cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) rst_q <= 1'b0;
    else rst_q <= uflow && wd_mode;

  assign reset_req = rst_q;
  assign irq       = irq_q;

  always_comb
    case (addr)
      2'd0:    rd_data = CNT_W'({irq_q, tap, src_osc, wd_mode, run});
      2'd1:    rd_data = reload;
      2'd2:    rd_data = cnt;
      default: rd_data = '0;
    endcase
endmodule

module guard_timer_chk #(
  parameter int PRE_W = 12,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             run,
  input logic             src_osc,
  input logic             pwr_down,
  input logic             wd_mode,
  input logic             feed_ok,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt,
  input logic [PRE_W-1:0] pre,
  input logic             reset_req,
  input logic             irq
);
  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    reset_req |=> !reset_req);
  // R5
  rst_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    reset_req |-> $past(wd_mode));
  // R6
  irq_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(irq) |-> !$past(wd_mode));
  // R3
  feed_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    feed_ok |=> (cnt == $past(reload) && pre == '0));
  // R9
  pd_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (run && !src_osc && pwr_down && !feed_ok) |=> ($stable(cnt) && $stable(pre)));
  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!run && !feed_ok) |=> ($stable(cnt) && $stable(pre)));
endmodule

bind guard_timer guard_timer_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .por_n(por_n), .run(run), .src_osc(src_osc), .pwr_down(pwr_down),
  .wd_mode(wd_mode), .feed_ok(feed_ok), .reload(reload), .cnt(cnt), .pre(pre),
  .reset_req(reset_req), .irq(irq));

// File: tb/guard_timer_test.sv
module guard_timer_test;
  logic clk = 0, por_n = 0, osc_tick = 0, pwr_down = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic reset_req, irq;
  int checks = 0, errors = 0;

  guard_timer uut (.clk(clk), .por_n(por_n), .osc_tick(osc_tick), .pwr_down(pwr_down),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .reset_req(reset_req), .irq(irq));

  always #10 clk = ~clk;

  // mode, tap, reload, expected edges from feed to underflow
  localparam int NV = 6;
  localparam int V_MODE[NV] = '{1, 1, 0, 0, 1, 0};
  localparam int V_TAP [NV] = '{0, 0, 1, 0, 2, 7};
  localparam int V_REL [NV] = '{0, 3, 2, 1, 1, 0};
  localparam int V_EXP [NV] = '{32, 128, 192, 64, 256, 4096};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5); wr(2'd2, 8'h5A);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    @(negedge clk); @(negedge clk); por_n = 1; @(negedge clk);

    rd(0, v); chk(v == 8'h02, "R1 ctrl", v, 8'h02);
    rd(1, v); chk(v == 8'hFF, "R1 reload", v, 8'hFF);
    rd(2, v); chk(v == 8'hFF, "R1 counter", v, 8'hFF);
    chk(!reset_req && !irq, "R1 outputs", {reset_req, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] cw;
      cw = {2'b00, 3'(V_TAP[i]), 1'b0, 1'(V_MODE[i]), 1'b1};
      wr(0, 8'h00);
      wr(1, 8'(V_REL[i]));
      wr(0, cw);
      feed();
      n = 0;
      while (!reset_req && !irq && n < V_EXP[i] + 10) begin
        @(posedge clk); @(negedge clk); n++;
      end
      chk(n == V_EXP[i], "R4 timeout", n, V_EXP[i]);
      if (V_MODE[i] == 1) begin
        chk(reset_req && !irq, "R5 reset not irq", {reset_req, irq}, 2'b10);
        rd(1, v); chk(v == 8'(V_REL[i]), "R10 reload kept", v, V_REL[i]);
        rd(0, v); chk(v == cw, "R10 ctrl kept", v, cw);
        idle(1);
        chk(!reset_req, "R5 one-cycle pulse", reset_req, 0);
      end else begin
        chk(irq && !reset_req, "R6 irq not reset", {reset_req, irq}, 2'b01);
      end
    end

    // R6 auto-reload period, R7 flag clear
    wr(0, 8'h00);
    wr(1, 8'd1);
    wr(0, 8'h01);
    feed();
    n = 0;
    while (!irq && n < 80) begin @(posedge clk); @(negedge clk); n++; end
    chk(n == 64, "R6 first period", n, 64);
    addr = 0; wr_data = 8'h01; wr_en = 1;
    @(posedge clk); @(negedge clk); wr_en = 0; n = 1;
    chk(!irq, "R7 clear by write 0", irq, 0);
    while (!irq && n < 80) begin @(posedge clk); @(negedge clk); n++; end
    chk(n == 64, "R6 auto-reload period", n, 64);
    chk(!reset_req, "R6 no reset", reset_req, 0);
    wr(0, 8'h00);
    chk(!irq, "R7 cleared", irq, 0);
    wr(0, 8'h40);
    rd(0, v); chk(v == 8'h00, "R7 write 1 no set", v, 8'h00);

    // R3 feed sequence, run = 0
    wr(0, 8'h02);
    wr(1, 8'h40); feed();
    rd(2, v); chk(v == 8'h40, "R3 feed loads", v, 8'h40);
    wr(2, 8'hA5); wr(1, 8'h10); wr(2, 8'h5A);
    rd(2, v); chk(v == 8'h40, "R3 abort by other write", v, 8'h40);
    wr(2, 8'hA5); idle(3); wr(2, 8'h5A);
    rd(2, v); chk(v == 8'h10, "R3 idle gap allowed", v, 8'h10);
    wr(1, 8'h33); wr(2, 8'h5A); wr(2, 8'h5A);
    rd(2, v); chk(v == 8'h10, "R3 wrong first byte", v, 8'h10);
    wr(2, 8'hA5); wr(2, 8'h00); wr(2, 8'h5A);
    rd(2, v); chk(v == 8'h10, "R3 abort by feed addr", v, 8'h10);

    // R11 halt
    idle(100);
    rd(2, v); chk(v == 8'h10, "R11 halted", v, 8'h10);

    // R9 power-down with peripheral clock
    pwr_down = 1;
    wr(1, 8'h20); feed();
    wr(0, 8'h03);
    idle(100);
    rd(2, v); chk(v == 8'h20, "R9 pd holds", v, 8'h20);
    pwr_down = 0;
    idle(64);
    rd(2, v); chk(v == 8'h1E, "R8 pclk counts", v, 8'h1E);

    // R8 oscillator source, R9 no effect on it
    wr(0, 8'h02); feed();
    wr(0, 8'h07);
    idle(100);
    rd(2, v); chk(v == 8'h20, "R8 no osc ticks", v, 8'h20);
    osc_tick = 1; pwr_down = 1;
    idle(64);
    osc_tick = 0;
    rd(2, v); chk(v == 8'h1E, "R9 osc ignores pd", v, 8'h1E);
    pwr_down = 0;
    chk(!reset_req && !irq, "R2 outputs quiet", {reset_req, irq}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule